// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Cache

This block sits in front of a one-time-programmable fuse array. Each fuse is one bit: an unblown fuse reads 0, and blowing it sets it to 1 for good. The controller keeps a volatile shadow copy of every fuse word. Commands address one word by bank and word index. There are four commands. A read returns the word from the shadow copy. A sense returns the word straight from the array. A program blows bits in the array. An override writes the shadow copy only. Because these are separate paths, software can make the shadow copy differ from the fuses on purpose, for example to change a cached setting for a while.

After reset the controller copies the whole array into the shadow copy, one word per cycle. Programming is bit-serial: only the bits that are 1 in the data and still 0 in the array are blown, one at a time. Each blow takes a parameterised number of cycles. A parameter decides whether the shadow word is reloaded from the array once programming ends. The array itself sits outside the block. It offers a combinational read port, and it takes a blow strobe together with a word address and a bit index.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Reset drives `busy` high with `ack`, `err` and `rdata` at 0. After reset is released, the controller spends exactly BANKS*WORDS cycles copying the array into the shadow copy, with `busy` high, and ignores every command during that time.
- R2: A read (`cmd` = 0) returns the addressed shadow word on `rdata`, with `ack`, one cycle after the request.
- R3: A sense (`cmd` = 1) returns the addressed fuse-array word on `rdata`, with `ack`, one cycle after the request, and leaves the shadow copy unchanged.
- R4: An override (`cmd` = 3) writes `wdata` into the addressed shadow word only, and acknowledges one cycle after the request. The fuse array is not touched.
- R5: A program (`cmd` = 2) leaves the fuse word equal to its old value OR `wdata`. A 0 in `wdata` never changes a bit, and no command ever clears a blown fuse. When it finishes, `rdata` shows the new fuse word.
- R6: With RELOAD = 1 the shadow word equals the new fuse word after a program. With RELOAD = 0 the shadow word keeps its previous value.
- R7: A program blows only bits that are set in `wdata` and still 0 in the array, one bit at a time, each taking BLOW_CYC cycles. `ack` therefore comes k*BLOW_CYC+2 cycles after the request, where k is the number of bits it actually blows. An already blown bit costs no cycle and never receives a blow strobe.
- R8: While `busy` is high, requests produce no acknowledge and have no effect.
- R9: A request whose bank is at least BANKS, or whose word is at least WORDS, is acknowledged after one cycle with `err` high for exactly one cycle and `rdata` = 0. It changes neither the array nor the shadow copy.
- R10: Word width (up to 32 bits), words per bank and bank count are parameters. The flat array index is bank*WORDS+word. The block works both with 8-bit words and with 32-bit words.
- R11: `ack` is a single-cycle pulse per accepted command, and it is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the load sequence |
| req | input | 1 | Command request, sampled when not busy |
| cmd | input | 2 | 0 read, 1 sense, 2 program, 3 override |
| bank | input | BANK_AW | Bank index |
| word | input | WORD_AW | Word index within the bank |
| wdata | input | WORD_W | Program bits or override value |
| ack | output | 1 | One-cycle command completion |
| err | output | 1 | One-cycle out-of-range flag, together with ack |
| rdata | output | WORD_W | Result word, valid with ack |
| busy | output | 1 | High during load and programming |
| fuse_addr | output | FA_W | Flat word address to the fuse array |
| fuse_rdata | input | WORD_W | Combinational fuse word at fuse_addr |
| fuse_blow | output | 1 | Blow strobe for one bit |
| fuse_bit | output | BIT_W | Bit index to blow |

## Verification
The bench runs two small configurations: 8-bit words with reload enabled and two-cycle blows, and 32-bit words with reload disabled and one-cycle blows. Every word is read and sensed after power-up. Every word is then overridden with a value distinct from its fuses, which shows that read follows the shadow copy while sense follows the array. Every word is then programmed with a data pattern that partly overlaps bits already blown, and the acknowledge latency is compared against the number of new bits. This separates blowing only new bits from blowing every set bit. The remaining stimuli are all-zero data, repeated data, requests sent while busy, out-of-range addresses that would alias to valid words if truncated, and a second reset that has to restore the shadow copy from the array.

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl #(
  parameter int WORD_W   = 8,
  parameter int WORDS    = 256,
  parameter int BANKS    = 2,
  parameter int BANK_AW  = 2,
  parameter int WORD_AW  = 9,
  parameter int BLOW_CYC = 4,
  parameter bit RELOAD   = 1'b1,
  localparam int N     = BANKS * WORDS,
  localparam int FA_W  = (N > 1) ? $clog2(N) : 1,
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int BC_W  = $clog2(BLOW_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [1:0]         cmd,
  input  logic [BANK_AW-1:0] bank,
  input  logic [WORD_AW-1:0] word,
  input  logic [WORD_W-1:0]  wdata,
  output logic               ack,
  output logic               err,
  output logic [WORD_W-1:0]  rdata,
  output logic               busy,
  output logic [FA_W-1:0]    fuse_addr,
  input  logic [WORD_W-1:0]  fuse_rdata,
  output logic               fuse_blow,
  output logic [BIT_W-1:0]   fuse_bit
);

  localparam logic [1:0] CMD_RD  = 2'd0;
  localparam logic [1:0] CMD_SNS = 2'd1;
  localparam logic [1:0] CMD_PRG = 2'd2;
  localparam logic [1:0] CMD_OVR = 2'd3;

  typedef enum logic [1:0] {S_LOAD, S_IDLE, S_PROG} st_t;

  st_t               state;
  logic [WORD_W-1:0] shadow [N];
  logic [FA_W-1:0]   idx, paddr, req_addr, sh_wa;
  logic [WORD_W-1:0] pend, sh_wd;
  logic [BC_W-1:0]   bcnt;
  logic              in_rng, accept, sh_we, prog_done, bit_last;

  function automatic logic [BIT_W-1:0] lowbit(input logic [WORD_W-1:0] v);
    lowbit = '0;
    for (int b = WORD_W - 1; b >= 0; b--)
      if (v[b]) lowbit = BIT_W'(b);
  endfunction

  assign in_rng    = (32'(bank) < BANKS) && (32'(word) < WORDS);
  assign req_addr  = FA_W'(32'(bank) * WORDS + 32'(word));
  assign accept    = (state == S_IDLE) && req;
  assign busy      = (state != S_IDLE);
  assign prog_done = (state == S_PROG) && (pend == '0);
  assign bit_last  = (bcnt == BC_W'(BLOW_CYC - 1));
  assign fuse_bit  = lowbit(pend);
  assign fuse_blow = (state == S_PROG) && (pend != '0) && bit_last;

  always_comb begin
    case (state)
      S_LOAD:  fuse_addr = idx;
      S_PROG:  fuse_addr = paddr;
      default: fuse_addr = req_addr;
    endcase
  end

  always_comb begin
    sh_we = 1'b0;
    sh_wa = idx;
    sh_wd = fuse_rdata;
    if (state == S_LOAD) begin
      sh_we = 1'b1;
    end else if (accept && in_rng && cmd == CMD_OVR) begin
      sh_we = 1'b1;
      sh_wa = req_addr;
      sh_wd = wdata;
    end else if (prog_done && RELOAD) begin
      sh_we = 1'b1;
      sh_wa = paddr;
    end
  end

  always_ff @(posedge clk)
    if (sh_we) shadow[sh_wa] <= sh_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOAD;
      idx   <= '0;
      paddr <= '0;
      pend  <= '0;
      bcnt  <= '0;
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (state)
        S_LOAD: begin
          idx <= idx + 1'b1;
          if (idx == FA_W'(N - 1)) state <= S_IDLE;
        end
        S_IDLE: if (req) begin
          if (!in_rng) begin
            ack   <= 1'b1;
            err   <= 1'b1;
            rdata <= '0;
          end else begin
            case (cmd)
              CMD_RD:  begin ack <= 1'b1; rdata <= shadow[req_addr]; end
              CMD_SNS: begin ack <= 1'b1; rdata <= fuse_rdata; end
              CMD_PRG: begin
                state <= S_PROG;
                paddr <= req_addr;
                pend  <= wdata & ~fuse_rdata;
                bcnt  <= '0;
              end
              default: ack <= 1'b1;
            endcase
          end
        end
        S_PROG: begin
          if (pend == '0) begin
            ack   <= 1'b1;
            rdata <= fuse_rdata;
            state <= S_IDLE;
          end else if (bit_last) begin
            pend[fuse_bit] <= 1'b0;
            bcnt           <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  blow_unblown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_blow |-> !fuse_rdata[fuse_bit]);

  // R9
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ack && rdata == '0));

  // R11
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);

  // R8
  blow_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_blow |-> busy);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

// File: tb/test_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_tb_core #(
  parameter int W  = 8,
  parameter int WPB = 8,
  parameter int NB = 2,
  parameter bit RL = 1'b1,
  parameter int BC = 2
) (
  input  logic clk,
  output int   npass,
  output int   nfail,
  output logic done
);
  localparam int N     = NB * WPB;
  localparam int FA_W  = (N > 1) ? $clog2(N) : 1;
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;

  logic rst_n, req, ack, err, busy, fuse_blow, preload;
  logic [1:0] cmd, bank;
  logic [3:0] word;
  logic [W-1:0] wdata, rdata, fuse_rdata;
  logic [FA_W-1:0] fuse_addr;
  logic [BIT_W-1:0] fuse_bit;
  logic [W-1:0] fz [N];
  logic [W-1:0] ef [N];
  logic [W-1:0] es [N];

  function automatic logic [W-1:0] pat(input int i);
    logic [31:0] v;
    v = (32'(i) * 32'h9E3779B1) ^ 32'h5A3C_0F96 ^ (32'(i) << 5);
    return v[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < N; i++) fz[i] <= pat(i);
    end else if (fuse_blow) begin
      fz[fuse_addr][fuse_bit] <= 1'b1;
    end
  end
  assign fuse_rdata = fz[fuse_addr];

  otp_fuse_ctrl #(.WORD_W(W), .WORDS(WPB), .BANKS(NB), .BANK_AW(2), .WORD_AW(4),
                  .BLOW_CYC(BC), .RELOAD(RL)) i_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .bank(bank), .word(word),
    .wdata(wdata), .ack(ack), .err(err), .rdata(rdata), .busy(busy),
    .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata), .fuse_blow(fuse_blow),
    .fuse_bit(fuse_bit));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) npass++;
    else begin
      nfail++;
      $display("FAIL %s (W=%0d): actual %0h expected %0h", tag, W, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input int b, input int w, input logic [W-1:0] d,
                       output logic [W-1:0] rd, output logic er, output int lat);
    @(negedge clk);
    req = 1'b1; cmd = c; bank = 2'(b); word = 4'(w); wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!ack && lat < 2000) begin @(negedge clk); lat++; end
    rd = rdata;
    er = err;
  endtask

  task automatic reset_and_load();
    int cnt;
    logic seen;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd1);
    chk("R1 ack/err/rdata in reset", {ack, err, 30'(rdata)}, 32'd0);
    rst_n = 1'b1;
    req = 1'b1; cmd = 2'd0; bank = 2'd0; word = 4'd0;
    @(negedge clk);
    req = 1'b0;
    cnt = 1; seen = ack;
    while (busy && cnt < 5000) begin @(negedge clk); cnt++; seen |= ack; end
    chk("R1 load cycles", 32'(cnt), 32'(N));
    chk("R1 request during load ignored", 32'(seen), 32'd0);
    for (int i = 0; i < N; i++) es[i] = ef[i];
  endtask

  initial begin
    logic [W-1:0] rd, d;
    logic er;
    int lat, k, t, acks;
    bit ok;
    npass = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; preload = 1'b1; req = 1'b0; cmd = '0; bank = '0; word = '0; wdata = '0;
    for (int i = 0; i < N; i++) ef[i] = pat(i);
    @(negedge clk); @(negedge clk);
    preload = 1'b0;
    reset_and_load();

    for (int i = 0; i < N; i++) begin
      issue(2'd0, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R2 R10 read after load", 32'(rd), 32'(es[i]));
      chk("R2 read latency", 32'(lat), 32'd1);
      issue(2'd1, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R3 sense after load", 32'(rd), 32'(ef[i]));
    end
    @(negedge clk);
    chk("R11 ack single cycle", 32'(ack), 32'd0);

    t = 0;
    for (int i = N - 1; i >= 0; i--) if (ef[i] != '1) t = i;
    d = ~ef[t];
    k = $countones(d);
    @(negedge clk);
    req = 1'b1; cmd = 2'd2; bank = 2'(t / WPB); word = 4'(t % WPB); wdata = d;
    @(negedge clk);
    cmd = 2'd3; bank = 2'(((t + 1) % N) / WPB); word = 4'(((t + 1) % N) % WPB); wdata = ~es[(t + 1) % N];
    chk("R8 busy while programming", 32'(busy), 32'd1);
    @(negedge clk);
    req = 1'b0;
    chk("R8 no ack for request while busy", 32'(ack), 32'd0);
    lat = 2;
    while (!ack && lat < 2000) begin @(negedge clk); lat++; end
    chk("R7 latency with busy request", 32'(lat), 32'(k * BC + 2));
    ef[t] = ef[t] | d;
    if (RL) es[t] = ef[t];
    acks = 0;
    repeat (4) begin @(negedge clk); acks += int'(ack); end
    chk("R8 ignored request never acked", 32'(acks), 32'd0);
    issue(2'd0, ((t + 1) % N) / WPB, ((t + 1) % N) % WPB, '0, rd, er, lat);
    chk("R8 ignored override left shadow", 32'(rd), 32'(es[(t + 1) % N]));

    for (int i = 0; i < N; i++) begin
      es[i] = ~ef[i] ^ W'(i);
      issue(2'd3, i / WPB, i % WPB, es[i], rd, er, lat);
      chk("R4 override ack latency", 32'(lat), 32'd1);
    end
    for (int i = 0; i < N; i++) begin
      issue(2'd0, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R4 read follows override", 32'(rd), 32'(es[i]));
      issue(2'd1, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R3 R4 sense ignores override", 32'(rd), 32'(ef[i]));
    end

    for (int i = 0; i < N; i++) begin
      d = pat(i + 7);
      k = $countones(d & ~ef[i]);
      issue(2'd2, i / WPB, i % WPB, d, rd, er, lat);
      chk("R7 program latency", 32'(lat), 32'(k * BC + 2));
      chk("R5 program result word", 32'(rd), 32'(ef[i] | d));
      ef[i] = ef[i] | d;
      if (RL) es[i] = ef[i];
    end
    ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (fz[i] !== ef[i]) ok = 1'b0;
      issue(2'd0, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R6 shadow after program", 32'(rd), 32'(es[i]));
      issue(2'd1, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R5 sense after program", 32'(rd), 32'(ef[i]));
    end
    chk("R5 array is old OR data", 32'(ok), 32'd1);

    issue(2'd2, 0, 0, '0, rd, er, lat);
    chk("R5 R7 zero data latency", 32'(lat), 32'd2);
    chk("R5 zero data no change", 32'(fz[0]), 32'(ef[0]));
    issue(2'd2, 1, 1, ef[WPB + 1], rd, er, lat);
    chk("R7 blown bits cost nothing", 32'(lat), 32'd2);
    chk("R5 reprogram keeps word", 32'(fz[WPB + 1]), 32'(ef[WPB + 1]));

    issue(2'd0, NB, 0, '0, rd, er, lat);
    chk("R9 bad bank err", {31'd0, er}, 32'd1);
    chk("R9 bad bank rdata", 32'(rd), 32'd0);
    chk("R9 bad bank latency", 32'(lat), 32'd1);
    @(negedge clk);
    chk("R9 err one cycle", 32'(err), 32'd0);
    issue(2'd2, 0, WPB, '1, rd, er, lat);
    chk("R9 bad word err", {31'd0, er}, 32'd1);
    chk("R9 bad word no programming", 32'(fz[WPB]), 32'(ef[WPB]));
    issue(2'd1, 3, 1, '0, rd, er, lat);
    chk("R9 bad bank sense rdata", 32'(rd), 32'd0);
    issue(2'd3, 3, 1, ~es[(3 * WPB + 1) % N], rd, er, lat);
    chk("R9 bad override err", {31'd0, er}, 32'd1);
    issue(2'd0, ((3 * WPB + 1) % N) / WPB, 1, '0, rd, er, lat);
    chk("R9 bad override no shadow change", 32'(rd), 32'(es[(3 * WPB + 1) % N]));

    reset_and_load();
    for (int i = 0; i < N; i++) begin
      issue(2'd0, i / WPB, i % WPB, '0, rd, er, lat);
      chk("R1 reload restores shadow", 32'(rd), 32'(ef[i]));
    end
    done = 1'b1;
  end
endmodule

module test_otp_fuse_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int p0, f0, p1, f1;
  logic d0, d1;

  otp_tb_core #(.W(8),  .WPB(8), .NB(2), .RL(1'b1), .BC(2)) i_otp_fuse_ctrl (
    .clk(clk), .npass(p0), .nfail(f0), .done(d0));
  otp_tb_core #(.W(32), .WPB(8), .NB(2), .RL(1'b0), .BC(1)) i_otp_fuse_ctrl_w32 (
    .clk(clk), .npass(p1), .nfail(f1), .done(d1));

  initial begin
    int cyc, fails;
    cyc = 0;
    fails = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 150000) begin
      fails = 1;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    #1;
    $display("%0d/%0d checks passed", p0 + p1, p0 + p1 + f0 + f1 + fails);
    $finish;
  end
endmodule